// File: doc/BRIEF.md
# SPI Frame Command Engine

This block is a register-programmed serial flash controller engine for transfers that software starts one word at a time. Software programs a clock word and a device-control word, loads up to four 32-bit data registers, then writes a command word. The command picks one of four chip selects, a word length, a frame length and an operation. A write shifts one word out on data lane 0. A read shifts one word in on one, two or four lanes and packs it into the data registers.

A chip select stays active across the successive word commands of one frame. It is released when the programmed number of words has completed, or at once when an end-frame command arrives. Software polls a status word for busy and word-complete. A divider derives the serial clock from the functional clock. Each chip select has its own clock polarity, clock phase and select polarity.

Top module: `spi_frame_engine`

## Requirements
- R1: Registers are addressed by `reg_addr`: 0 clock, 1 device control, 2 command (reads as 0), 3 status (read only), 4..7 data words 0..3. After reset the status reads 0, every chip-select pin is at logic 1, `sclk_o` is 0 and `lane_oe0` is 0.
- R2: A command word carries the chip-select index in bits 29:28, word length minus one in bits 25:19, the operation in bits 18:16 and frame length minus one in bits 11:0. Operation 2 (write) shifts the low L bits of the data registers out on `lane_out0`, most significant bit first, with `lane_oe0` high only while that word is in progress.
- R3: A 128-bit write sends data word 3 first and data word 0 last.
- R4: Accepting a read or write command sets busy (status bit 0) and clears word-complete (status bit 1) at the next edge. After (L / lanes) x (divisor + 1) functional clock cycles, busy reads 0 and word-complete reads 1.
- R5: Operation 1 (single read) samples lane 1 once per serial clock. The received L-bit word lands in the low bits of the data registers, and all other data bits read 0.
- R6: Operation 3 (dual read) samples lanes 1:0 and operation 7 (quad read) samples lanes 3:0 each serial clock. The higher-numbered lane is the more significant bit and the first sample is the most significant.
- R7: The clock word holds an enable in bit 31 and a divisor D in bits 15:0. Each serial clock period lasts D+1 functional cycles. With phase 0 the clock is at its idle level for the first (D+1)/2 cycles of the period (rounded down) and at the opposite level for the rest. Between words the serial clock rests at the clock polarity of the last selected chip select.
- R8: Device control holds an 8-bit slice per chip select n starting at bit 8n: bit 0 clock polarity, bit 1 select polarity (1 = active high), bit 2 clock phase, bits 4:3 stored only. Only the indexed chip-select pin is ever driven to its active level.
- R9: The chip select stays active between the words of one frame. It returns to its inactive level when the last word of the programmed frame length completes.
- R10: Operation 4 (end frame), written while idle, returns the active chip select to its inactive level at the next edge.
- R11: A command written while busy is ignored, as are operations 0, 5 and 6. Busy, word-complete, the chip selects and the word in progress are unchanged.
- R12: While the clock enable is 0, a started word makes no progress: busy stays set and the serial clock does not toggle. Setting the enable resumes the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | functional clock |
| rst_n | input | 1 | active-low asynchronous reset |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | 3 | register index |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data (combinational) |
| sclk_o | output | 1 | serial clock |
| cs_o | output | 4 | chip-select pins, level set by per-select polarity |
| lane_out0 | output | 1 | serial data out on lane 0 |
| lane_oe0 | output | 1 | output enable for lane 0 |
| lane_in | input | 4 | serial data lanes in |

## Verification
The bench builds the engine with its defaults: four chip selects, four 32-bit data words (a 128-bit shift path) and a 12-bit frame counter. That makes the full 128-bit write and quad read reachable, with every chip-select slice and index decode. The divisor is a run-time setting, so the bench drives it to 3 and 5. This shows the odd/even split of the serial clock period and the cycle-exact busy window while keeping 128-bit words short. Frames of one, three and four words cover the automatic release, the held select between words and the early end-frame release.

// File: rtl/spi_fce_pkg.sv
package spi_fce_pkg;
    // register indices
    localparam logic [2:0] RIX_CLK    = 3'd0;
    localparam logic [2:0] RIX_DEVCTL = 3'd1;
    localparam logic [2:0] RIX_CMD    = 3'd2;
    localparam logic [2:0] RIX_STAT   = 3'd3;

    // command field positions
    localparam int CMD_CS_LSB   = 28;
    localparam int CMD_WL_LSB   = 19;
    localparam int CMD_OP_LSB   = 16;

    typedef enum logic [2:0] {
        OP_IDLE = 3'd0,
        OP_RD1  = 3'd1,
        OP_WR1  = 3'd2,
        OP_RD2  = 3'd3,
        OP_ENDF = 3'd4,
        OP_RD4  = 3'd7
    } op_e;
endpackage

// File: rtl/spi_fce_clkdiv.sv
module spi_fce_clkdiv #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             bit_end,
    output logic             hi_phase
);
    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic [DIV_W:0]   half;

    always_comb begin
        half     = ({1'b0, div} + 1'b1) >> 1;
        bit_end  = run && (cnt_q >= div);
        hi_phase = ({1'b0, cnt_q} >= half);
        if (!run)         cnt_d = '0;
        else if (bit_end) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // stalled or idle engine keeps the period counter parked
    p_idle_cnt_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);
endmodule

// File: rtl/spi_fce_csdrv.sv
module spi_fce_csdrv #(
    parameter int NUM_CS = 4,
    parameter int CS_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_frame,
    input  logic [CS_W-1:0]   cs_idx,
    input  logic [NUM_CS-1:0] cs_pol,
    output logic [NUM_CS-1:0] cs_o
);
    logic [NUM_CS-1:0] act;

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign act[i]  = in_frame && (cs_idx == CS_W'(i));
        assign cs_o[i] = act[i] ? cs_pol[i] : ~cs_pol[i];
    end

    p_one_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act));
    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_frame |-> act == '0);
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
    import spi_fce_pkg::*;
#(
    parameter int NUM_CS   = 4,
    parameter int DATA_W   = 32,
    parameter int NUM_DATA = 4,
    parameter int DIV_W    = 16,
    parameter int FRAME_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              sclk_o,
    output logic [NUM_CS-1:0] cs_o,
    output logic              lane_out0,
    output logic              lane_oe0,
    input  logic [3:0]        lane_in
);
    localparam int SHIFT_W = DATA_W * NUM_DATA;
    localparam int CS_W    = $clog2(NUM_CS);
    localparam int DC_W    = NUM_CS * 8;
    localparam int BL_W    = $clog2(SHIFT_W) + 1;
    localparam int DIX_W   = $clog2(NUM_DATA);
    localparam int WL_W    = 7;

    typedef struct packed {
        logic                clk_en;
        logic [DIV_W-1:0]    div;
        logic [DC_W-1:0]     dc;
        logic [SHIFT_W-1:0]  sh;
        logic                busy;
        logic                wc;
        logic                is_wr;
        logic [2:0]          lane_w;
        logic [BL_W-1:0]     bits_left;
        logic                in_frame;
        logic [CS_W-1:0]     cs_idx;
        logic [FRAME_W-1:0]  frame_left;
    } st_t;

    st_t s_q, s_d;

    logic              bit_end, hi_phase, run;
    logic              start, endf, cmd_hit, last_bit;
    op_e               op;
    logic [BL_W-1:0]   wlen;
    logic [BL_W-1:0]   sh_amt;
    logic [DIX_W-1:0]  dix;
    logic [NUM_CS-1:0] cs_pol;
    logic              cpol, cpha;

    assign run = s_q.busy && s_q.clk_en;

    spi_fce_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .div      (s_q.div),
        .bit_end  (bit_end),
        .hi_phase (hi_phase)
    );

    always_comb begin
        s_d      = s_q;
        op       = op_e'(reg_wdata[CMD_OP_LSB +: 3]);
        wlen     = BL_W'(reg_wdata[CMD_WL_LSB +: WL_W]) + 1'b1;
        sh_amt   = BL_W'(SHIFT_W) - wlen;
        dix      = reg_addr[DIX_W-1:0];
        cmd_hit  = reg_we && (reg_addr == RIX_CMD) && !s_q.busy;
        start    = cmd_hit && (op == OP_RD1 || op == OP_WR1 || op == OP_RD2 || op == OP_RD4);
        endf     = cmd_hit && (op == OP_ENDF);
        last_bit = s_q.bits_left <= BL_W'(s_q.lane_w);

        if (reg_we) begin
            case (reg_addr)
                RIX_CLK: begin
                    s_d.clk_en = reg_wdata[31];
                    s_d.div    = reg_wdata[DIV_W-1:0];
                end
                RIX_DEVCTL: s_d.dc = reg_wdata[DC_W-1:0];
                RIX_CMD, RIX_STAT: ;
                default: if (!s_q.busy) s_d.sh[int'(dix)*DATA_W +: DATA_W] = reg_wdata[DATA_W-1:0];
            endcase
        end

        if (start) begin
            s_d.busy      = 1'b1;
            s_d.wc        = 1'b0;
            s_d.is_wr     = (op == OP_WR1);
            s_d.lane_w    = (op == OP_RD4) ? 3'd4 : (op == OP_RD2) ? 3'd2 : 3'd1;
            s_d.bits_left = wlen;
            s_d.sh        = (op == OP_WR1) ? (s_q.sh << sh_amt) : '0;
            if (!s_q.in_frame) begin
                s_d.in_frame   = 1'b1;
                s_d.cs_idx     = reg_wdata[CMD_CS_LSB +: CS_W];
                s_d.frame_left = reg_wdata[FRAME_W-1:0];
            end
        end else if (endf) begin
            s_d.in_frame   = 1'b0;
            s_d.frame_left = '0;
        end else if (bit_end) begin
            if (s_q.is_wr) s_d.sh = s_q.sh << 1;
            else begin
                case (s_q.lane_w)
                    3'd4:    s_d.sh = {s_q.sh[SHIFT_W-5:0], lane_in};
                    3'd2:    s_d.sh = {s_q.sh[SHIFT_W-3:0], lane_in[1:0]};
                    default: s_d.sh = {s_q.sh[SHIFT_W-2:0], lane_in[1]};
                endcase
            end
            if (last_bit) begin
                s_d.busy      = 1'b0;
                s_d.wc        = 1'b1;
                s_d.bits_left = '0;
                if (s_q.frame_left == '0) s_d.in_frame   = 1'b0;
                else                      s_d.frame_left = s_q.frame_left - 1'b1;
            end else begin
                s_d.bits_left = s_q.bits_left - BL_W'(s_q.lane_w);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // read path and pins
    always_comb begin
        for (int i = 0; i < NUM_CS; i++) cs_pol[i] = s_q.dc[8*i + 1];
        cpol = s_q.dc[{s_q.cs_idx, 3'd0}];
        cpha = s_q.dc[{s_q.cs_idx, 3'd2}];
        case (reg_addr)
            RIX_CLK:    reg_rdata = {s_q.clk_en, {(31-DIV_W){1'b0}}, s_q.div};
            RIX_DEVCTL: reg_rdata = s_q.dc;
            RIX_CMD:    reg_rdata = '0;
            RIX_STAT:   reg_rdata = {30'd0, s_q.wc, s_q.busy};
            default:    reg_rdata = s_q.sh[int'(dix)*DATA_W +: DATA_W];
        endcase
    end

    assign sclk_o    = s_q.busy ? (cpol ^ (cpha ? ~hi_phase : hi_phase)) : cpol;
    assign lane_oe0  = s_q.busy && s_q.is_wr;
    assign lane_out0 = lane_oe0 && s_q.sh[SHIFT_W-1];

    spi_fce_csdrv #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_cs (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_frame (s_q.in_frame),
        .cs_idx   (s_q.cs_idx),
        .cs_pol   (cs_pol),
        .cs_o     (cs_o)
    );

    p_start_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> s_q.busy && !s_q.wc);
    p_done_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.busy) |-> s_q.wc);
    p_oe_in_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lane_oe0 |-> s_q.busy);
    p_end_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
        endf |=> !s_q.in_frame);
    p_busy_cmd_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == RIX_CMD && s_q.busy) |=> s_q.busy && $stable(s_q.cs_idx));
    p_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !s_q.clk_en && !(reg_we && reg_addr == RIX_CLK)) |=>
            s_q.busy && $stable(s_q.bits_left));
endmodule

// File: tb/spi_frame_engine_test.sv
module spi_frame_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd3;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sclk_o, lane_out0, lane_oe0;
    logic [3:0]  cs_o;
    logic [3:0]  lane_in = '0;

    int tests = 0, fails = 0;
    logic [127:0] exp_v[$];
    int           exp_l[$];

    always #10 clk = ~clk;

    spi_frame_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk_o(sclk_o),
        .cs_o(cs_o), .lane_out0(lane_out0), .lane_oe0(lane_oe0), .lane_in(lane_in)
    );

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_cmd(int cs, int wl, int op, int fl);
        return (32'(cs) << 28) | (32'(wl - 1) << 19) | (32'(op) << 16) | 32'(fl - 1);
    endfunction

    task automatic wreg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 3'd3;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata; reg_addr = 3'd3; #1;
    endtask

    task automatic push_exp(input logic [127:0] v, input int l);
        exp_v.push_back(v); exp_l.push_back(l);
    endtask

    // wait for the word in progress, feeding read lanes on each rising serial clock
    task automatic run_busy(input logic [127:0] src, input int lw, input int l,
                            output int nb, output int nhi, output logic [3:0] cs_mid);
        logic [127:0] s;
        logic prev;
        s = src << (128 - l);
        prev = sclk_o; nb = 0; nhi = 0; cs_mid = cs_o;
        forever begin
            reg_addr = 3'd3; #1;
            if (!reg_rdata[0]) break;
            nb++;
            if (sclk_o) nhi++;
            if (sclk_o && !prev) begin
                if (lw == 4)      lane_in = s[127:124];
                else if (lw == 2) lane_in = {2'b00, s[127:126]};
                else              lane_in = {2'b00, s[127], 1'b0};
                s = s << lw;
            end
            prev = sclk_o;
            @(negedge clk);
        end
    endtask

    task automatic word(input logic [31:0] cmd, input logic [127:0] src, input int lw,
                        input int l, output int nb, output int nhi, output logic [3:0] cs_mid);
        wreg(3'd2, cmd);
        run_busy(src, lw, l, nb, nhi, cs_mid);
    endtask

    // scoreboard monitor: collects lane 0 bits on rising serial clock while driven
    initial begin
        logic [127:0] cap = '0;
        int ncap = 0;
        logic ps = 1'b0, po = 1'b0;
        forever begin
            @(negedge clk);
            if (lane_oe0 && sclk_o && !ps) begin
                cap = {cap[126:0], lane_out0}; ncap++;
            end
            if (po && !lane_oe0 && ncap > 0) begin
                if (exp_v.size() == 0) check("R2 unexpected word", cap, '0);
                else begin
                    check("R2 R3 write stream", cap, exp_v.pop_front());
                    check("R2 write length", 128'(ncap), 128'(exp_l.pop_front()));
                end
                cap = '0; ncap = 0;
            end
            ps = sclk_o; po = lane_oe0;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int nb, nhi;
        logic [3:0] cm;

        repeat (3) @(negedge clk);
        // R1 reset state
        rreg(3'd3, d); check("R1 status", d, 0);
        check("R1 cs pins", cs_o, 4'b1111);
        check("R1 sclk", sclk_o, 0);
        check("R1 oe", lane_oe0, 0);
        rst_n = 1'b1;

        wreg(3'd0, 32'h8000_0003);
        rreg(3'd0, d); check("R7 clock readback", d, 32'h8000_0003);

        // R2 8-bit write, single word frame
        wreg(3'd4, 32'h0000_00A5);
        push_exp(128'hA5, 8);
        word(mk_cmd(0, 8, 2, 1), 0, 1, 8, nb, nhi, cm);
        check("R4 busy cycles 8b", nb, 32);
        check("R7 high cycles D=3", nhi, 16);
        check("R8 cs0 active", cm, 4'b1110);
        check("R9 release after frame", cs_o, 4'b1111);
        rreg(3'd3, d); check("R4 done status", d, 2);
        @(negedge clk);

        // R2 16 and 32 bit writes
        wreg(3'd4, 32'h0000_C0DE);
        push_exp(128'hC0DE, 16);
        word(mk_cmd(0, 16, 2, 1), 0, 1, 16, nb, nhi, cm);
        check("R4 busy cycles 16b", nb, 64);
        wreg(3'd4, 32'h1234_5678);
        push_exp(128'h1234_5678, 32);
        word(mk_cmd(0, 32, 2, 1), 0, 1, 32, nb, nhi, cm);
        @(negedge clk);

        // R3 128-bit write ordering
        wreg(3'd7, 32'h1111_2222); wreg(3'd6, 32'h3333_4444);
        wreg(3'd5, 32'h5555_6666); wreg(3'd4, 32'h7777_8888);
        push_exp(128'h1111_2222_3333_4444_5555_6666_7777_8888, 128);
        word(mk_cmd(0, 128, 2, 1), 0, 1, 128, nb, nhi, cm);
        check("R3 busy cycles 128b", nb, 512);
        @(negedge clk);

        // R5 single read on lane 1, upper bits cleared
        wreg(3'd5, 32'hFFFF_FFFF);
        word(mk_cmd(0, 8, 1, 1), 128'hC3, 1, 8, nb, nhi, cm);
        check("R4 busy read 8b", nb, 32);
        check("R2 oe low on read", lane_oe0, 0);
        rreg(3'd4, d); check("R5 single read", d, 32'h0000_00C3);
        rreg(3'd5, d); check("R5 upper cleared", d, 0);

        // R6 dual and quad reads
        word(mk_cmd(0, 16, 3, 1), 128'hB4E1, 2, 16, nb, nhi, cm);
        check("R6 dual busy", nb, 32);
        rreg(3'd4, d); check("R6 dual read", d, 32'h0000_B4E1);
        word(mk_cmd(0, 32, 7, 1), 128'hDEAD_BEEF, 4, 32, nb, nhi, cm);
        check("R6 quad busy", nb, 32);
        rreg(3'd4, d); check("R6 quad read", d, 32'hDEAD_BEEF);
        word(mk_cmd(0, 128, 7, 1), 128'h0123_4567_89AB_CDEF_0F1E_2D3C_4B5A_6978, 4, 128, nb, nhi, cm);
        rreg(3'd7, d); check("R6 quad128 word3", d, 32'h0123_4567);
        rreg(3'd6, d); check("R6 quad128 word2", d, 32'h89AB_CDEF);
        rreg(3'd4, d); check("R6 quad128 word0", d, 32'h4B5A_6978);

        // R7 divisor 5: 6 cycles per bit, 3 high
        wreg(3'd0, 32'h8000_0005);
        wreg(3'd4, 32'h0000_005A);
        push_exp(128'h5A, 8);
        word(mk_cmd(0, 8, 2, 1), 0, 1, 8, nb, nhi, cm);
        check("R7 busy cycles D=5", nb, 48);
        check("R7 high cycles D=5", nhi, 24);
        wreg(3'd0, 32'h8000_0003);

        // R9 three-word frame on cs2
        for (int k = 0; k < 3; k++) begin
            wreg(3'd4, 32'(8'h10 + k));
            push_exp(128'(8'h10 + k), 8);
            word(mk_cmd(2, 8, 2, 3), 0, 1, 8, nb, nhi, cm);
            check("R8 cs2 active", cm, 4'b1011);
            if (k < 2) check("R9 held between words", cs_o, 4'b1011);
            else       check("R9 released at frame end", cs_o, 4'b1111);
        end

        // R10 end frame releases early
        wreg(3'd4, 32'h0000_0077);
        push_exp(128'h77, 8);
        word(mk_cmd(3, 8, 2, 4), 0, 1, 8, nb, nhi, cm);
        check("R9 held mid frame", cs_o, 4'b0111);
        wreg(3'd2, mk_cmd(3, 8, 4, 1));
        check("R10 end frame release", cs_o, 4'b1111);

        // R8 select polarity and R7 clock polarity on cs1
        wreg(3'd1, 32'h0000_0300);
        check("R8 idle active-high cs", cs_o, 4'b1101);
        word(mk_cmd(1, 8, 1, 1), 0, 1, 8, nb, nhi, cm);
        check("R8 active-high asserted", cm, 4'b1111);
        check("R8 active-high released", cs_o, 4'b1101);
        check("R7 idle polarity", sclk_o, 1);
        wreg(3'd1, 32'h0000_0000);

        // R11 command while busy ignored, undefined op ignored
        wreg(3'd4, 32'h0000_003C);
        push_exp(128'h3C, 8);
        wreg(3'd2, mk_cmd(0, 8, 2, 1));
        wreg(3'd2, mk_cmd(1, 32, 7, 1));
        run_busy(0, 1, 8, nb, nhi, cm);
        check("R11 busy window unchanged", nb, 30);
        check("R11 select unchanged", cm, 4'b1110);
        repeat (3) @(negedge clk);
        rreg(3'd3, d); check("R11 no restart", d, 2);
        wreg(3'd2, mk_cmd(0, 8, 5, 1));
        @(negedge clk);
        rreg(3'd3, d); check("R11 op5 ignored status", d, 2);
        check("R11 op5 ignored cs", cs_o, 4'b1111);

        // R12 clock disabled stalls the word
        wreg(3'd0, 32'h0000_0003);
        wreg(3'd4, 32'h0000_0081);
        push_exp(128'h81, 8);
        wreg(3'd2, mk_cmd(0, 8, 2, 1));
        nhi = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (sclk_o) nhi++;
        end
        rreg(3'd3, d); check("R12 still busy", d, 1);
        check("R12 no serial clock", nhi, 0);
        wreg(3'd0, 32'h8000_0003);
        run_busy(0, 1, 8, nb, nhi, cm);
        rreg(3'd3, d); check("R12 resumed done", d, 2);

        repeat (4) @(negedge clk);
        check("R2 scoreboard drained", exp_v.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule